// File: doc/BRIEF.md
# Dual-Mode Video Pixel Input Formatter

This block sits at the front of a digital display transmitter. It takes a parallel video bus and turns it into one 24-bit pixel per clock period. A mode pin picks one of two bus formats. In the wide format, all 24 data lines carry a whole pixel, and that pixel is taken on the rising clock edge. In the narrow format, only the low 12 lines carry pixel data. The half on those lines at the rising edge becomes the low half of the pixel. The half present at the following falling edge becomes the high half. The data-enable, both sync inputs and three control bits are taken on the rising edge, at the same time as the first half.

In every cycle, the assembled word goes out on three encoder channels. Each channel has a byte field, a two-bit control field and a data-enable qualifier. During active video the bytes carry colour and the control fields are zero. During blanking the bytes are zero and the control fields carry the syncs and control bits. In narrow mode, lines 23..16 carry no pixel data. Their level is sampled every rising edge into an 8-bit configuration register, which a host reads through a plain read port. The mode pin is read only while reset is held.

Top module: `vid_pixel_formatter`

## Requirements
- R1: In wide mode (mode latched high), a word driven on `pixIn[23:0]` with `deIn` high at rising edge k appears on `encData` after rising edge k+1.
- R2: In narrow mode (mode latched low), `pixIn[11:0]` at rising edge k becomes pixel bits 11:0. `pixIn[11:0]` at the falling edge that follows becomes pixel bits 23:12. The joined pixel appears on `encData` after rising edge k+1.
- R3: Channel byte mapping: `encData[7:0]` = pixel[7:0], `encData[15:8]` = pixel[15:8], `encData[23:16]` = pixel[23:16].
- R4: Blanking control mapping: `encCtl[1:0]` = {vsync, hsync}, `encCtl[3:2]` = {ctlIn[1], ctlIn[0]}, `encCtl[5:4]` = {1'b0, ctlIn[2]}.
- R5: When the captured data-enable is high, `encCtl` is all zero. When it is low, `encData` is all zero.
- R6: All three bits of `encDe` equal the captured data-enable. They share the two-edge latency of the data and control fields.
- R7: In narrow mode, `cfgData` takes `pixIn[23:16]` at every rising edge outside reset.
- R8: `cfgData` reads zero after reset. In wide mode it holds its value whatever is on `pixIn[23:16]`.
- R9: While `rstN` is low at a rising edge, all outputs go to the blanking state after that edge: `encDe`, `encCtl` and `encData` all zero.
- R10: `wideSel` is sampled only at rising edges with `rstN` low. A change while running has no effect on the format until the next reset.
- R11: In narrow mode, `pixIn[23:12]` has no effect on the pixel fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; both edges are used in narrow mode |
| rstN | input | 1 | Active-low synchronous reset, sampled on the rising edge |
| wideSel | input | 1 | Format select: 1 = 24-bit single edge, 0 = 12-bit dual edge |
| pixIn | input | 24 | Parallel video data bus |
| deIn | input | 1 | Data enable: 1 = active video, 0 = blanking |
| hsyncIn | input | 1 | Horizontal sync |
| vsyncIn | input | 1 | Vertical sync |
| ctlIn | input | 3 | Control bits sent during blanking |
| encData | output | 24 | Three 8-bit channel data fields, channel 0 in the low byte |
| encCtl | output | 6 | Three 2-bit channel control fields, channel 0 in the low pair |
| encDe | output | 3 | Per-channel data-enable qualifier |
| cfgData | output | 8 | Host-readable configuration byte |

## Verification
The assertions assume that the inputs are driven from time zero and that `rstN` starts low. This lets every past-value term look back to a sampled reset rather than to unknown values. They also assume that in narrow mode the bus is stable around both clock edges. The stimulus meets both assumptions: it holds reset from the first instant, and it changes the bus only one nanosecond after an edge, so each half is stable across the edge that captures it. The mode pin is changed while running on purpose, to exercise the requirement that such a change is ignored.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  // Strobes from the control unit to the capture datapath
  typedef struct packed {
    logic clear;   // synchronous clear of all capture state
    logic wide;    // latched format: 1 = single-edge full word
    logic hiEn;    // load the high half on the falling edge
    logic cfgEn;   // sample the configuration byte
  } strobe_t;

endpackage

// File: rtl/vpf_ctrl.sv
module vpf_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wideSel,
  output vpf_pkg::strobe_t  strb,
  output logic              modeWide
);

  logic modeLatch;

  // Format pin is only honoured while reset is asserted
  always_ff @(posedge clk) begin
    if (!rstN) modeLatch <= wideSel;
  end

  always_comb begin
    strb.clear = !rstN;
    strb.wide  = modeLatch;
    strb.hiEn  = !modeLatch;
    strb.cfgEn = !modeLatch;
  end

  assign modeWide = modeLatch;

endmodule

// File: rtl/vpf_datapath.sv
module vpf_datapath #(
  parameter int HALF_W = 12,
  parameter int CH_W   = 8,
  parameter int CTL_W  = 3,
  parameter int CFG_W  = 8,
  localparam int PIX_W  = 2 * HALF_W,
  localparam int NUM_CH = PIX_W / CH_W,
  localparam int CTLV_W = 2 * NUM_CH
) (
  input  logic                 clk,
  input  vpf_pkg::strobe_t     strb,
  input  logic [PIX_W-1:0]     pixIn,
  input  logic                 deIn,
  input  logic                 hsyncIn,
  input  logic                 vsyncIn,
  input  logic [CTL_W-1:0]     ctlIn,
  output logic [PIX_W-1:0]     encData,
  output logic [CTLV_W-1:0]    encCtl,
  output logic [NUM_CH-1:0]    encDe,
  output logic [CFG_W-1:0]     cfgData
);

  localparam int CFG_LSB = PIX_W - CFG_W;

  logic [PIX_W-1:0]  capPix;
  logic [HALF_W-1:0] hiHalf;
  logic              capDe, capHs, capVs;
  logic [CTL_W-1:0]  capCtl;
  logic [CFG_W-1:0]  cfgReg;
  logic [PIX_W-1:0]  joinedPix;
  logic [CTLV_W-1:0] ctlVec;

  // Rising-edge capture: full word or low half, plus qualifiers
  always_ff @(posedge clk) begin
    if (strb.clear) begin
      capPix <= '0;
      capDe  <= 1'b0;
      capHs  <= 1'b0;
      capVs  <= 1'b0;
      capCtl <= '0;
    end else begin
      capPix <= pixIn;
      capDe  <= deIn;
      capHs  <= hsyncIn;
      capVs  <= vsyncIn;
      capCtl <= ctlIn;
    end
  end

  // Falling-edge capture of the second half in narrow mode
  always_ff @(negedge clk) begin
    if (strb.clear)     hiHalf <= '0;
    else if (strb.hiEn) hiHalf <= pixIn[HALF_W-1:0];
  end

  // Configuration byte from the idle upper lines
  always_ff @(posedge clk) begin
    if (strb.clear)      cfgReg <= '0;
    else if (strb.cfgEn) cfgReg <= pixIn[CFG_LSB +: CFG_W];
  end

  assign cfgData   = cfgReg;
  assign joinedPix = strb.wide ? capPix : {hiHalf, capPix[HALF_W-1:0]};

  always_comb begin
    ctlVec = '0;
    ctlVec[1:0] = {capVs, capHs};
    ctlVec[2 +: CTL_W] = capCtl;
  end

  // Per-channel output stage
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (strb.clear) begin
        encData[c*CH_W +: CH_W] <= '0;
        encCtl[2*c +: 2]        <= '0;
        encDe[c]                <= 1'b0;
      end else begin
        encData[c*CH_W +: CH_W] <= capDe ? joinedPix[c*CH_W +: CH_W] : '0;
        encCtl[2*c +: 2]        <= capDe ? 2'b00 : ctlVec[2*c +: 2];
        encDe[c]                <= capDe;
      end
    end
  end

endmodule

// File: rtl/vid_pixel_formatter.sv
module vid_pixel_formatter #(
  parameter int HALF_W = 12,
  parameter int CH_W   = 8,
  parameter int CTL_W  = 3,
  parameter int CFG_W  = 8,
  localparam int PIX_W  = 2 * HALF_W,
  localparam int NUM_CH = PIX_W / CH_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wideSel,
  input  logic [PIX_W-1:0]      pixIn,
  input  logic                  deIn,
  input  logic                  hsyncIn,
  input  logic                  vsyncIn,
  input  logic [CTL_W-1:0]      ctlIn,
  output logic [PIX_W-1:0]      encData,
  output logic [2*NUM_CH-1:0]   encCtl,
  output logic [NUM_CH-1:0]     encDe,
  output logic [CFG_W-1:0]      cfgData
);

  vpf_pkg::strobe_t strb;
  logic             modeWide;

  vpf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wideSel  (wideSel),
    .strb     (strb),
    .modeWide (modeWide)
  );

  vpf_datapath #(
    .HALF_W (HALF_W),
    .CH_W   (CH_W),
    .CTL_W  (CTL_W),
    .CFG_W  (CFG_W)
  ) u_dp (
    .clk     (clk),
    .strb    (strb),
    .pixIn   (pixIn),
    .deIn    (deIn),
    .hsyncIn (hsyncIn),
    .vsyncIn (vsyncIn),
    .ctlIn   (ctlIn),
    .encData (encData),
    .encCtl  (encCtl),
    .encDe   (encDe),
    .cfgData (cfgData)
  );

endmodule

// File: rtl/vpf_checker.sv
module vpf_checker (
  input logic        clk,
  input logic        rstN,
  input logic        modeWide,
  input logic [23:0] pixIn,
  input logic        deIn,
  input logic [23:0] encData,
  input logic [5:0]  encCtl,
  input logic [2:0]  encDe,
  input logic [7:0]  cfgData
);

  logic [1:0] seenCnt = 2'd0;
  always_ff @(posedge clk) begin
    if (seenCnt != 2'd3) seenCnt <= seenCnt + 2'd1;
  end

  // R5: active video carries no control, blanking carries no data
  assert_ctl_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    encDe[0] |-> encCtl == 6'd0);
  assert_data_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !encDe[0] |-> encData == 24'd0);

  // R6: the three qualifiers move together
  assert_de_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(encDe) == 0 || $countones(encDe) == 3);

  // R9: blanking state after a reset edge
  assert_reset_blank_R9: assert property (@(posedge clk)
    (seenCnt != 2'd0) && !$past(rstN) |-> (encDe == 3'd0 && encCtl == 6'd0 && encData == 24'd0));

  // R8: configuration byte reads zero after reset
  assert_cfg_clear_R8: assert property (@(posedge clk)
    (seenCnt != 2'd0) && !$past(rstN) |-> cfgData == 8'd0);

  // R8: configuration byte holds in wide mode
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (seenCnt >= 2'd2) && modeWide && $past(rstN) |-> $stable(cfgData));

  // R7: configuration byte follows upper lines in narrow mode
  assert_cfg_track_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seenCnt != 2'd0) && !modeWide && $past(rstN) |-> cfgData == $past(pixIn[23:16]));

  // R10: format does not change outside reset
  assert_mode_static_R10: assert property (@(posedge clk) disable iff (!rstN)
    (seenCnt != 2'd0) && $past(rstN) |-> $stable(modeWide));

  // R1: wide-mode word passes through with two-edge latency
  assert_wide_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (seenCnt >= 2'd2) && modeWide && $past(rstN) && $past(rstN, 2) && $past(deIn, 2)
      |-> encData == $past(pixIn, 2));

endmodule

bind vid_pixel_formatter vpf_checker u_vpf_checker (
  .clk      (clk),
  .rstN     (rstN),
  .modeWide (modeWide),
  .pixIn    (pixIn),
  .deIn     (deIn),
  .encData  (encData),
  .encCtl   (encCtl),
  .encDe    (encDe),
  .cfgData  (cfgData)
);

// File: tb/vid_pixel_formatter_tb.sv
module vid_pixel_formatter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wideSel = 1'b1;
  logic [23:0] pixIn = '0;
  logic        deIn = 1'b0;
  logic        hsyncIn = 1'b0;
  logic        vsyncIn = 1'b0;
  logic [2:0]  ctlIn = '0;
  logic [23:0] encData;
  logic [5:0]  encCtl;
  logic [2:0]  encDe;
  logic [7:0]  cfgData;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vid_pixel_formatter u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .wideSel (wideSel),
    .pixIn   (pixIn),
    .deIn    (deIn),
    .hsyncIn (hsyncIn),
    .vsyncIn (vsyncIn),
    .ctlIn   (ctlIn),
    .encData (encData),
    .encCtl  (encCtl),
    .encDe   (encDe),
    .cfgData (cfgData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req, input logic [23:0] pix, input logic de,
                              input logic hs, input logic vs, input logic [2:0] ct);
    logic [23:0] expData;
    logic [5:0]  expCtl;
    expData = de ? pix : 24'd0;
    expCtl  = de ? 6'd0 : {1'b0, ct, vs, hs};
    check({req, " data"}, {8'd0, encData}, {8'd0, expData});
    check({req, " ctl"},  {26'd0, encCtl}, {26'd0, expCtl});
    check({req, " de"},   {29'd0, encDe},  {29'd0, {3{de}}});
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk); #1;
    rstN = 1'b0; wideSel = mode;
    pixIn = 24'hFFFFFF; deIn = 1'b1; hsyncIn = 1'b1; vsyncIn = 1'b1; ctlIn = 3'b111;
    repeat (2) @(posedge clk);
    #1;
    checkOutputs("R9 reset", 24'd0, 1'b0, 1'b0, 1'b0, 3'd0);
    check("R8 cfg after reset", {24'd0, cfgData}, 32'd0);
    @(negedge clk); #1;
    rstN = 1'b1;
    deIn = 1'b0; hsyncIn = 1'b0; vsyncIn = 1'b0; ctlIn = 3'd0; pixIn = '0;
  endtask

  // Single-edge cycle: drive before edge k, check after edge k+1
  task automatic sendWide(input string req, input logic [23:0] pix, input logic de,
                          input logic hs, input logic vs, input logic [2:0] ct);
    @(negedge clk); #1;
    pixIn = pix; deIn = de; hsyncIn = hs; vsyncIn = vs; ctlIn = ct;
    @(posedge clk); #1;
    pixIn = ~pix; deIn = ~de; hsyncIn = ~hs; vsyncIn = ~vs; ctlIn = ~ct;
    @(posedge clk); #1;
    checkOutputs(req, pix, de, hs, vs, ct);
  endtask

  // Dual-edge cycle with junk on lines 15..12 and a config byte on 23..16
  task automatic sendNarrow(input string req, input logic [23:0] pix, input logic de,
                            input logic [7:0] cfg, input logic [3:0] junkA, input logic [3:0] junkB);
    @(negedge clk); #1;
    pixIn = {cfg, junkA, pix[11:0]}; deIn = de; hsyncIn = 1'b1; vsyncIn = 1'b0; ctlIn = 3'b101;
    @(posedge clk); #1;
    check({req, " R7 cfg capture"}, {24'd0, cfgData}, {24'd0, cfg});
    pixIn = {cfg, junkB, pix[23:12]}; deIn = ~de; hsyncIn = 1'b0; ctlIn = 3'b010;
    @(negedge clk); #1;
    pixIn = {cfg, 4'h0, 12'h000};
    @(posedge clk); #1;
    checkOutputs(req, pix, de, 1'b1, 1'b0, 3'b101);
  endtask

  task automatic testWidePatterns();
    sendWide("R1 R3 wide pattern A", 24'hA1B2C3, 1'b1, 1'b0, 1'b0, 3'd0);
    sendWide("R1 R3 wide pattern B", 24'h00FF00, 1'b1, 1'b1, 1'b1, 3'b111);
    sendWide("R1 R6 wide pattern C", 24'h5A0F96, 1'b1, 1'b0, 1'b1, 3'b010);
  endtask

  task automatic testBlanking();
    sendWide("R4 R5 blank hs", 24'h123456, 1'b0, 1'b1, 1'b0, 3'b000);
    sendWide("R4 R5 blank vs ctl0", 24'hFFFFFF, 1'b0, 1'b0, 1'b1, 3'b001);
    sendWide("R4 R5 blank ctl1", 24'h0000AA, 1'b0, 1'b0, 1'b0, 3'b010);
    sendWide("R4 R5 blank ctl2", 24'h808080, 1'b0, 1'b1, 1'b1, 3'b100);
  endtask

  task automatic testWideCfgHold();
    sendWide("R8 wide hold pixel", 24'hC3FFEE, 1'b1, 1'b0, 1'b0, 3'd0);
    check("R8 cfg holds in wide", {24'd0, cfgData}, 32'd0);
  endtask

  task automatic testModeChange();
    // R10: drop the pin while running; format must stay wide
    @(negedge clk); #1; wideSel = 1'b0;
    sendWide("R10 pin change ignored", 24'h9ABCDE, 1'b1, 1'b0, 1'b0, 3'd0);
    check("R10 cfg untouched", {24'd0, cfgData}, 32'd0);
  endtask

  task automatic testNarrow();
    sendNarrow("R2 R11 narrow A", 24'h3C5A69, 1'b1, 8'h5D, 4'hF, 4'h3);
    sendNarrow("R2 R11 narrow B", 24'hFEDCBA, 1'b1, 8'hA2, 4'h0, 4'hC);
    sendNarrow("R2 R5 narrow blank", 24'h111111, 1'b0, 8'h77, 4'h9, 4'h6);
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset(1'b1);
    testWidePatterns();
    testBlanking();
    testWideCfgHold();
    testModeChange();
    doReset(1'b0);   // R10: new format takes effect at reset
    testNarrow();
    doReset(1'b1);   // R8: cleared again, then held in wide mode
    testWideCfgHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule